// File: doc/BRIEF.md
# ADC Conversion Cycle Sequencer

This block sequences the operating cycle of a multichannel delta-sigma converter. After an asynchronous reset it holds a power-on interval and then starts the first conversion on the default channel pair. When the conversion engine reports done, it pulses a strobe that loads the result register, and then it drops into a low-power sleep state. It stays asleep until the serial slave front end reports that the device has been addressed.

During the bus transfer phase the sequencer watches event strobes from the front end. A channel write is held pending. A stop after a write, or after a read that ended early, starts a new conversion. A read of all 24 result bits starts one at once. A stop after a transfer that did neither returns the block to sleep. While the power-on interval or a conversion is running, the busy output tells the front end to refuse every request, and the sequencer ignores every bus strobe.

The conversion itself is outside this block. A stand-in engine, typically a programmable-length counter, receives `conv_start` and answers with `conv_done`.

Top module: `adc_cycle_seq`

## Requirements
- R1: While `rst_n` is low: `busy`=1, `asleep`=0, `conv_start`=0, `result_latch`=0, and `chan_sel`=0. Channel code 0 selects CH0 as the positive input and CH1 as the negative input.
- R2: The first `conv_start` is a one-cycle pulse. It occurs in the clock cycle after POR_CYCLES-1 rising edges have passed since `rst_n` went high.
- R3: `busy` stays high from reset until `conv_done` arrives during a conversion. In that cycle `result_latch` pulses and `busy` is already low. `asleep` is high from the next cycle.
- R4: In sleep, `bus_wr_done`, `bus_rd_partial`, `bus_rd_all` and `bus_stop` have no effect and `asleep` stays high indefinitely. `bus_addr` ends sleep, and `asleep` is low from the next cycle.
- R5: During a transfer, a `bus_stop` after a `bus_wr_done` pulses `conv_start` in the same cycle as the stop.
- R6: During a transfer, a `bus_stop` after a `bus_rd_partial` pulses `conv_start` in the same cycle as the stop.
- R7: During a transfer, `bus_rd_all` pulses `conv_start` in the same cycle. A later `bus_stop` causes no second start.
- R8: A `bus_stop` during a transfer that had no write and no partial read starts no conversion. `asleep` is high from the next cycle.
- R9: `wr_chan` captured with `bus_wr_done` during a transfer appears on `chan_sel` in the cycle after the next `conv_start`. Without a write, the previous channel is kept.
- R10: While `busy` is high, every bus strobe is ignored: no start, no wake-up, and no channel capture.
- R11: `result_latch` pulses only for a `conv_done` that arrives during a conversion. A `conv_done` in sleep is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Front end reports the device was addressed |
| bus_wr_done | input | 1 | A valid channel write completed |
| wr_chan | input | CHAN_W | Channel code carried by the write |
| bus_rd_partial | input | 1 | A read ended before all result bits |
| bus_rd_all | input | 1 | All 24 result bits were read |
| bus_stop | input | 1 | Stop condition detected |
| conv_done | input | 1 | Conversion engine finished |
| conv_start | output | 1 | One-cycle start pulse to the engine |
| busy | output | 1 | Refuse bus requests |
| asleep | output | 1 | Block is in sleep |
| chan_sel | output | CHAN_W | Channel code used by the conversion |
| result_latch | output | 1 | Load the 24-bit result register |

## Verification
The bench targets the exact cycle of the first start after reset. A counter that is off by one moves that pulse a cycle early or late. It sends strobes while the block is asleep and while it is converting. A design that woke up or started on those strobes would produce a start that no driver expected, and a design that stored a channel during a conversion would report the wrong channel on the next conversion. It also checks a stop that follows a complete read, and a stop that follows a bare address. A design that re-armed on either one would start a conversion twice or leave sleep when it should not.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_XFER  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_seq_por_timer.sv
module adc_seq_por_timer #(
  parameter int POR_CYCLES = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expired
);
  localparam int CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = active && (cnt_q == LAST);
  assign cnt_en  = active && !expired;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_seq_arm.sv
module adc_seq_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic in_xfer,
  input  logic set_ev,
  output logic armed
);
  logic armed_d;

  always_comb begin
    armed_d = armed;
    if (!in_xfer)    armed_d = 1'b0;
    else if (set_ev) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= armed_d;
  end
endmodule

// File: rtl/adc_seq_chan_reg.sv
module adc_seq_chan_reg #(
  parameter int          CHAN_W       = 4,
  parameter logic [CHAN_W-1:0] DEFAULT_CHAN = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic              apply,
  output logic [CHAN_W-1:0] chan_sel
);
  logic [CHAN_W-1:0] pend_q;
  logic [CHAN_W-1:0] next_chan;

  always_comb next_chan = capture ? wr_chan : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= DEFAULT_CHAN;
    else if (capture) pend_q <= wr_chan;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chan_sel <= DEFAULT_CHAN;
    else if (apply) chan_sel <= next_chan;
  end
endmodule

// File: rtl/adc_cycle_seq.sv
module adc_cycle_seq
  import adc_seq_pkg::*;
#(
  parameter int POR_CYCLES = 400000,
  parameter int CHAN_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr_done,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic              bus_rd_partial,
  input  logic              bus_rd_all,
  input  logic              bus_stop,
  input  logic              conv_done,
  output logic              conv_start,
  output logic              busy,
  output logic              asleep,
  output logic [CHAN_W-1:0] chan_sel,
  output logic              result_latch
);
  seq_state_e st_q, st_d;
  logic in_por, in_conv, in_sleep, in_xfer;
  logic por_expired, armed, arm_ev, stop_fire, start_xfer;

  assign in_por   = (st_q == ST_POR);
  assign in_conv  = (st_q == ST_CONV);
  assign in_sleep = (st_q == ST_SLEEP);
  assign in_xfer  = (st_q == ST_XFER);

  adc_seq_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst_n(rst_n), .active(in_por), .expired(por_expired)
  );

  assign arm_ev = in_xfer && (bus_wr_done || bus_rd_partial);

  adc_seq_arm u_arm (
    .clk(clk), .rst_n(rst_n), .in_xfer(in_xfer), .set_ev(arm_ev), .armed(armed)
  );

  assign stop_fire  = bus_stop && (armed || bus_wr_done || bus_rd_partial);
  assign start_xfer = in_xfer && (bus_rd_all || stop_fire);

  assign conv_start   = (in_por && por_expired) || start_xfer;
  assign result_latch = in_conv && conv_done;
  assign busy         = in_por || (in_conv && !conv_done);
  assign asleep       = in_sleep;

  adc_seq_chan_reg #(.CHAN_W(CHAN_W), .DEFAULT_CHAN('0)) u_chan (
    .clk(clk), .rst_n(rst_n),
    .capture(in_xfer && bus_wr_done), .wr_chan(wr_chan),
    .apply(conv_start), .chan_sel(chan_sel)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_POR:   if (por_expired) st_d = ST_CONV;
      ST_CONV:  if (conv_done)   st_d = ST_SLEEP;
      ST_SLEEP: if (bus_addr)    st_d = ST_XFER;
      ST_XFER: begin
        if (start_xfer)    st_d = ST_CONV;
        else if (bus_stop) st_d = ST_SLEEP;
      end
      default: st_d = ST_POR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_POR;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/adc_cycle_seq_sva.sv
module adc_cycle_seq_sva #(
  parameter int CHAN_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_addr,
  input logic              conv_done,
  input logic              conv_start,
  input logic              busy,
  input logic              asleep,
  input logic [CHAN_W-1:0] chan_sel,
  input logic              result_latch
);
  AST_START_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> busy); // R2
  AST_LATCH_FREES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    result_latch |-> !busy); // R3
  AST_LATCH_THEN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    result_latch |=> asleep); // R3
  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !bus_addr) |=> asleep); // R4
  AST_SLEEP_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!busy && !conv_start)); // R10
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(conv_start)) |-> $stable(chan_sel)); // R9
  AST_LATCH_ONLY_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    result_latch |-> (conv_done && $past(busy))); // R11
  AST_START_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_start, result_latch})); // R11
endmodule

bind adc_cycle_seq adc_cycle_seq_sva #(.CHAN_W(CHAN_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .conv_done(conv_done),
  .conv_start(conv_start), .busy(busy), .asleep(asleep),
  .chan_sel(chan_sel), .result_latch(result_latch)
);

// File: tb/adc_cycle_seq_bench.sv
module adc_cycle_seq_bench;
  localparam int P  = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_addr = 0, bus_wr_done = 0, bus_rd_partial = 0, bus_rd_all = 0;
  logic bus_stop = 0, conv_done = 0;
  logic [CW-1:0] wr_chan = '0;
  logic conv_start, busy, asleep, result_latch;
  logic [CW-1:0] chan_sel;

  int checks = 0;
  int fails  = 0;
  logic [CW-1:0] exp_q[$];
  logic          mon_armed = 1'b0;
  logic [CW-1:0] mon_exp;

  always #2.5 clk = ~clk;

  adc_cycle_seq #(.POR_CYCLES(P), .CHAN_W(CW)) u_adc_cycle_seq (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_done(bus_wr_done),
    .wr_chan(wr_chan), .bus_rd_partial(bus_rd_partial), .bus_rd_all(bus_rd_all),
    .bus_stop(bus_stop), .conv_done(conv_done), .conv_start(conv_start),
    .busy(busy), .asleep(asleep), .chan_sel(chan_sel), .result_latch(result_latch)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs at the falling edge, then let logic settle.
  task automatic cyc(input logic a, input logic w, input logic p, input logic r,
                     input logic s, input logic d, input logic [CW-1:0] ch);
    @(negedge clk);
    bus_addr = a; bus_wr_done = w; bus_rd_partial = p; bus_rd_all = r;
    bus_stop = s; conv_done = d; wr_chan = ch;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, '0);
  endtask

  task automatic expect_start(input logic [CW-1:0] ch);
    exp_q.push_back(ch);
  endtask

  task automatic finish_conv;
    cyc(0, 0, 0, 0, 0, 1, '0);
    chk(result_latch == 1'b1, "R3 latch", result_latch, 1);
    chk(busy == 1'b0, "R3 busy", busy, 0);
    cyc(0, 0, 0, 0, 0, 0, '0);
    chk(asleep == 1'b1, "R3 asleep", asleep, 1);
  endtask

  // Monitor: pops expected channels on each start, compares chan_sel next cycle.
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (mon_armed) begin
        chk(chan_sel == mon_exp, "R9 chan_sel", chan_sel, mon_exp);
        mon_armed = 1'b0;
      end
      if (conv_start) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected conv_start", 1, 0);
        end else begin
          mon_exp   = exp_q.pop_front();
          mon_armed = 1'b1;
        end
      end
    end
  end

  initial begin
    #(5ns * 20000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(busy == 1'b1, "R1 busy", busy, 1);
    chk(asleep == 1'b0, "R1 asleep", asleep, 0);
    chk(conv_start == 1'b0, "R1 conv_start", conv_start, 0);
    chk(result_latch == 1'b0, "R1 result_latch", result_latch, 0);
    chk(chan_sel == '0, "R1 chan_sel", chan_sel, 0);

    // R2 first start timing
    expect_start('0);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (n < 3 * P) begin
      @(negedge clk); #1;
      n++;
      if (conv_start) break;
    end
    chk(n == P - 1, "R2 por length", n, P - 1);
    idle(4);
    chk(busy == 1'b1, "R3 busy while converting", busy, 1);
    finish_conv();

    // R4/R11 sleep ignores strobes and stray done
    cyc(0, 1, 0, 0, 0, 0, 4'd5);
    cyc(0, 0, 1, 0, 1, 0, '0);
    cyc(0, 0, 0, 1, 0, 0, '0);
    cyc(0, 0, 0, 0, 0, 1, '0);
    chk(result_latch == 1'b0, "R11 done in sleep", result_latch, 0);
    idle(20);
    chk(asleep == 1'b1, "R4 stays asleep", asleep, 1);

    // R5 write then stop
    cyc(1, 0, 0, 0, 0, 0, '0);
    cyc(0, 0, 0, 0, 0, 0, '0);
    chk(asleep == 1'b0, "R4 wakes on address", asleep, 0);
    cyc(0, 1, 0, 0, 0, 0, 4'd2);
    idle(2);
    expect_start(4'd2);
    cyc(0, 0, 0, 0, 1, 0, '0);
    chk(conv_start == 1'b1, "R5 stop after write", conv_start, 1);
    idle(3);

    // R10 strobes during conversion are ignored
    cyc(1, 0, 0, 0, 0, 0, '0);
    cyc(0, 1, 0, 0, 0, 0, 4'd3);
    cyc(0, 0, 0, 0, 1, 0, '0);
    cyc(0, 0, 0, 1, 0, 0, '0);
    chk(busy == 1'b1, "R10 still busy", busy, 1);
    finish_conv();
    idle(2);
    chk(asleep == 1'b1, "R10 address while busy ignored", asleep, 1);

    // R6 partial read then stop; channel 2 kept (R9, R10)
    cyc(1, 0, 0, 0, 0, 0, '0);
    cyc(0, 0, 1, 0, 0, 0, '0);
    expect_start(4'd2);
    cyc(0, 0, 0, 0, 1, 0, '0);
    chk(conv_start == 1'b1, "R6 stop after partial read", conv_start, 1);
    idle(3);
    finish_conv();

    // R8 bare stop returns to sleep
    cyc(1, 0, 0, 0, 0, 0, '0);
    idle(2);
    cyc(0, 0, 0, 0, 1, 0, '0);
    chk(conv_start == 1'b0, "R8 bare stop", conv_start, 0);
    cyc(0, 0, 0, 0, 0, 0, '0);
    chk(asleep == 1'b1, "R8 back to sleep", asleep, 1);

    // R7 full read starts at once, later stop adds nothing
    cyc(1, 0, 0, 0, 0, 0, '0);
    cyc(0, 1, 0, 0, 0, 0, 4'd1);
    expect_start(4'd1);
    cyc(0, 0, 0, 1, 0, 0, '0);
    chk(conv_start == 1'b1, "R7 full read", conv_start, 1);
    cyc(0, 0, 0, 0, 1, 0, '0);
    chk(conv_start == 1'b0, "R7 no second start", conv_start, 0);
    idle(3);
    finish_conv();

    // R9 new channel after sleep
    cyc(1, 0, 0, 0, 0, 0, '0);
    cyc(0, 1, 0, 0, 1, 0, 4'd7);
    expect_start(4'd7);
    chk(conv_start == 1'b1, "R5 write with stop", conv_start, 1);
    idle(3);
    finish_conv();
    idle(3);
    chk(exp_q.size() == 0, "R9 all starts seen", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule